// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block sits behind a digital audio receiver front end and turns the decoded stereo samples into a serial stream. It drives a bit clock, a word clock and one data line. A two-bit source code picks one of three receiver channels, or it mutes the data line. A format input chooses between two word layouts: a long word sent least significant bit first, or a short word sent most significant bit first. When a sample arrives with its error flag set, the block sends the last sample it sent on that stereo channel again.

All timing comes from a master-rate clock enable. Two enable ticks make one bit clock period, and 64 bit clocks make one frame. The left channel fills the first half of the frame, with the word clock high. The right channel fills the second half, with the word clock low. The source code, the format, the samples and the error flags are all captured once, at the start of each frame. A stop input freezes the block and brings it back at a clean frame start. A lock input gates the two clock outputs.

Top module: `aud_serial_fmt`

## Requirements
- R1: Source code 00 sends source 0, 01 sends source 1 and 10 sends source 2. Source k sits in bits [k*20 +: 20] of the sample buses and in bit k of the error flag buses.
- R2: Source code 11 holds the data line low for the whole frame. The bit clock and the word clock keep running.
- R3: With fmt_long high, a slot carries the 20-bit sample least significant bit first, in slot positions 0 to 19. Positions 20 to 31 are low.
- R4: With fmt_long low, a slot carries sample bits 19 down to 4, most significant first, in slot positions 0 to 15. Positions 16 to 31 are low.
- R5: The data line changes only on the edge where the bit clock goes low, or while the bit clock is already low. It never changes while the bit clock is high.
- R6: A frame is 64 bit clocks long. The word clock is high for slot bits 0 to 31 (left) and low for bits 32 to 63 (right). The bit clock falls on one enable tick and rises on the next one.
- R7: If the error flag of the selected source is set for a channel, that channel sends the sample it sent in the previous frame. The stored value stays as it was.
- R8: After reset the stored samples of both channels are zero, so an error on the first frame sends silence.
- R9: While lock is low, bclk_o and wclk_o are low from the next clock cycle on.
- R10: One cycle after stop goes high, all outputs are low, and they stay low while stop is high. The stored samples are kept. The first enable tick after stop falls starts a frame at left bit 0.
- R11: The source code, the format, the samples and the error flags are captured only at the first falling bit-clock edge of a frame. A change in the middle of a frame takes effect in the next frame.
- R12: The bit clock changes state only on a cycle that follows an asserted mck_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mck_en | input | 1 | Master-rate enable; one tick per bit-clock half |
| lock | input | 1 | Receiver lock; gates the clock outputs |
| stop | input | 1 | Freeze; restart from a frame start on release |
| src_sel | input | 2 | Source code, 11 mutes the data line |
| fmt_long | input | 1 | 1: 20-bit LSB-first word, 0: 16-bit MSB-first word |
| smp_l | input | 60 | Left samples of the three sources |
| smp_r | input | 60 | Right samples of the three sources |
| err_l | input | 3 | Left error flag for each source |
| err_r | input | 3 | Right error flag for each source |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, high for left |
| sdata_o | output | 1 | Serial data |

## Verification
A wrong bit counter shows up within one frame: the word clock pattern shifts, and the data bits land at the wrong slot positions in a captured frame. A stale or corrupted stored sample stays hidden until a frame with an error flag. That frame then carries a value that does not match the last good one, so the concealment tests pair each error frame with the frame before it. A wrong frame-start capture shows up as bits from two settings mixed inside one frame, and the mid-frame change test looks for exactly that.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

  typedef enum logic [1:0] {
    SRC_0    = 2'b00,
    SRC_1    = 2'b01,
    SRC_2    = 2'b10,
    SRC_MUTE = 2'b11
  } src_code_e;

  // Bit of a slot at position pos: long LSB-first word or short MSB-first
  // word built from the upper bits of the sample; unused positions are low.
  function automatic logic slot_bit(input logic [31:0] word,
                                    input int unsigned long_w,
                                    input int unsigned short_w,
                                    input int unsigned pos,
                                    input logic        lsb_long);
    logic b;
    b = 1'b0;
    if (lsb_long) begin
      if (pos < long_w) b = word[pos[4:0]];
    end else if (pos < short_w) begin
      b = word[5'(long_w - 1 - pos)];
    end
    return b;
  endfunction

endpackage

// File: rtl/aud_bit_timer.sv
module aud_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic          rise_go,
  output logic          fall_go,
  output logic          frame_go,
  output logic [CW-1:0] cnt_nx
);
  logic          ph_q;   // 1: bit clock is in its high half (next tick falls)
  logic [CW-1:0] cnt_q;

  // Idle position is "last bit, high half": the first tick starts a frame.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q  <= 1'b1;
      cnt_q <= '1;
    end else if (tick) begin
      ph_q <= ~ph_q;
      if (ph_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rise_go  = tick && !ph_q && !clr && !rst;
    fall_go  = tick &&  ph_q && !clr && !rst;
    cnt_nx   = fall_go ? cnt_q + 1'b1 : cnt_q;
    frame_go = fall_go && (cnt_q == '1);
  end
endmodule

// File: rtl/aud_conceal.sv
module aud_conceal #(
  parameter int W    = 20,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [1:0]      sel_in,
  input  logic            fmt_in,
  input  logic [NSRC*W-1:0] smp_l,
  input  logic [NSRC*W-1:0] smp_r,
  input  logic [NSRC-1:0] err_l,
  input  logic [NSRC-1:0] err_r,
  output logic [W-1:0]    nxt_l,
  output logic [W-1:0]    nxt_r,
  output logic [1:0]      nxt_sel,
  output logic            nxt_fmt,
  output logic [W-1:0]    cur_l,
  output logic [W-1:0]    cur_r,
  output logic [1:0]      cur_sel,
  output logic            cur_fmt
);
  always_comb begin
    nxt_sel = sel_in;
    nxt_fmt = fmt_in;
    nxt_l   = cur_l;
    nxt_r   = cur_r;
    if (32'(sel_in) < NSRC) begin
      if (!err_l[sel_in]) nxt_l = smp_l[32'(sel_in)*W +: W];
      if (!err_r[sel_in]) nxt_r = smp_r[32'(sel_in)*W +: W];
    end
  end

  // The frame registers double as the "last sent" store for concealment.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_l   <= '0;
      cur_r   <= '0;
      cur_sel <= aud_fmt_pkg::SRC_MUTE;
      cur_fmt <= 1'b0;
    end else if (load) begin
      cur_l   <= nxt_l;
      cur_r   <= nxt_r;
      cur_sel <= nxt_sel;
      cur_fmt <= nxt_fmt;
    end
  end
endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt #(
  parameter int SMP_W    = 20,
  parameter int SHORT_W  = 16,
  parameter int NSRC     = 3,
  parameter int SLOT_LOG = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mck_en,
  input  logic                  lock,
  input  logic                  stop,
  input  logic [1:0]            src_sel,
  input  logic                  fmt_long,
  input  logic [NSRC*SMP_W-1:0] smp_l,
  input  logic [NSRC*SMP_W-1:0] smp_r,
  input  logic [NSRC-1:0]       err_l,
  input  logic [NSRC-1:0]       err_r,
  output logic                  bclk_o,
  output logic                  wclk_o,
  output logic                  sdata_o
);
  import aud_fmt_pkg::*;

  localparam int CW = SLOT_LOG + 1;

  logic             rise_go, fall_go, frame_go;
  logic [CW-1:0]    cnt_nx;
  logic [SMP_W-1:0] nl, nr, cl, cr, el, er, word;
  logic [1:0]       nsel, csel, esel;
  logic             nfmt, cfmt, efmt;
  logic             bclk_i, wclk_i, bclk_nx, wclk_nx, bit_nx;

  aud_bit_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(stop), .tick(mck_en),
    .rise_go(rise_go), .fall_go(fall_go), .frame_go(frame_go),
    .cnt_nx(cnt_nx)
  );

  aud_conceal #(.W(SMP_W), .NSRC(NSRC)) u_conceal (
    .clk(clk), .rst(rst), .load(frame_go),
    .sel_in(src_sel), .fmt_in(fmt_long),
    .smp_l(smp_l), .smp_r(smp_r), .err_l(err_l), .err_r(err_r),
    .nxt_l(nl), .nxt_r(nr), .nxt_sel(nsel), .nxt_fmt(nfmt),
    .cur_l(cl), .cur_r(cr), .cur_sel(csel), .cur_fmt(cfmt)
  );

  // Bit 0 of a frame is emitted on the same edge that captures the frame.
  always_comb begin
    esel    = frame_go ? nsel : csel;
    efmt    = frame_go ? nfmt : cfmt;
    el      = frame_go ? nl   : cl;
    er      = frame_go ? nr   : cr;
    word    = cnt_nx[CW-1] ? er : el;
    bit_nx  = (esel == SRC_MUTE) ? 1'b0 :
              slot_bit(32'(word), SMP_W, SHORT_W, 32'(cnt_nx[CW-2:0]), efmt);
    bclk_nx = rise_go ? 1'b1 : (fall_go ? 1'b0 : bclk_i);
    wclk_nx = fall_go ? ~cnt_nx[CW-1] : wclk_i;
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      bclk_i  <= 1'b0;
      wclk_i  <= 1'b0;
      bclk_o  <= 1'b0;
      wclk_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      bclk_i <= bclk_nx;
      wclk_i <= wclk_nx;
      bclk_o <= lock & bclk_nx;
      wclk_o <= lock & wclk_nx;
      if (fall_go) sdata_o <= bit_nx;
    end
  end
endmodule

// File: rtl/aud_serial_fmt_chk.sv
module aud_serial_fmt_chk (
  input logic clk,
  input logic rst,
  input logic mck_en,
  input logic lock,
  input logic stop,
  input logic bclk_o,
  input logic wclk_o,
  input logic sdata_o
);
  // R5: data never moves while the bit clock is high
  a_r5_data_on_low: assert property (@(posedge clk) disable iff (rst)
    (sdata_o != $past(sdata_o)) |-> !bclk_o);

  // R9: clock outputs are parked low while unlocked
  a_r9_clk_gated: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (!bclk_o && !wclk_o));

  // R10: stop clears every output on the next cycle
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!bclk_o && !wclk_o && !sdata_o));

  // R12: without an enable tick the bit clock holds its level
  a_r12_bclk_paced: assert property (@(posedge clk) disable iff (rst)
    (!mck_en && !stop && lock && $past(lock)) |=> $stable(bclk_o));
endmodule

bind aud_serial_fmt aud_serial_fmt_chk u_chk (
  .clk(clk), .rst(rst), .mck_en(mck_en), .lock(lock), .stop(stop),
  .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
);

// File: tb/aud_serial_fmt_test.sv
module aud_serial_fmt_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mck_en = 1'b0;
  logic        lock = 1'b1;
  logic        stop = 1'b1;
  logic [1:0]  src_sel = 2'b00;
  logic        fmt_long = 1'b1;
  logic [59:0] smp_l = '0;
  logic [59:0] smp_r = '0;
  logic [2:0]  err_l = '0;
  logic [2:0]  err_r = '0;
  logic        bclk_o, wclk_o, sdata_o;

  int checks = 0;
  int errors = 0;
  int pace = 1;
  int pc = 0;
  int cyc = 0;
  logic [63:0] gd, gw;
  int gi = 0;

  localparam logic [63:0] WS_EXP = 64'h0000_0000_FFFF_FFFF;

  aud_serial_fmt uut (
    .clk(clk), .rst(rst), .mck_en(mck_en), .lock(lock), .stop(stop),
    .src_sel(src_sel), .fmt_long(fmt_long), .smp_l(smp_l), .smp_r(smp_r),
    .err_l(err_l), .err_r(err_r),
    .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pc >= pace - 1) begin pc <= 0; mck_en <= 1'b1; end
    else begin pc <= pc + 1; mck_en <= 1'b0; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung (got timeout, exp completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [19:0] l, input logic [19:0] r,
                                            input logic lsb20, input logic mute);
    logic [63:0] f;
    f = '0;
    for (int i = 0; i < 64; i++) begin
      logic [19:0] w;
      int p;
      w = (i < 32) ? l : r;
      p = i % 32;
      if (!mute) begin
        if (lsb20) f[i] = (p < 20) ? w[p] : 1'b0;
        else       f[i] = (p < 16) ? w[19-p] : 1'b0;
      end
    end
    return f;
  endfunction

  // Capture n bits, one at each rising bit-clock edge.
  task automatic grab(input int n);
    for (int k = 0; k < n; k++) begin
      logic p;
      p = bclk_o;
      @(negedge clk);
      while (!(bclk_o && !p)) begin
        p = bclk_o;
        @(negedge clk);
      end
      gd[gi] = sdata_o;
      gw[gi] = wclk_o;
      gi++;
    end
  endtask

  task automatic restart();
    stop = 1'b1;
    repeat (2) @(negedge clk);
    stop = 1'b0;
    gi = 0;
  endtask

  task automatic frame_chk(input string req, input logic [63:0] exp);
    chk(gd == exp, req, gd, exp);
    chk(gw == WS_EXP, {req, " R6 word clock"}, gw, WS_EXP);
  endtask

  task automatic t_reset_state();
    chk({bclk_o, wclk_o, sdata_o} == 3'b000, "R8 reset outputs", 64'({bclk_o, wclk_o, sdata_o}), 64'h0);
    src_sel = 2'b00; fmt_long = 1'b1;
    smp_l[0 +: 20] = 20'hABCDE; smp_r[0 +: 20] = 20'h12345;
    err_l = 3'b001; err_r = 3'b001;
    stop = 1'b0; gi = 0;
    grab(64);
    frame_chk("R8 first error frame silent", 64'h0);
    err_l = '0; err_r = '0;
  endtask

  task automatic t_route();
    for (int s = 0; s < 3; s++) begin
      smp_l[s*20 +: 20] = 20'h1A2B0 + 20'(s * 20'h31F07);
      smp_r[s*20 +: 20] = 20'hF0E1D - 20'(s * 20'h0A5C3);
    end
    for (int s = 0; s < 3; s++) begin
      src_sel = 2'(s); fmt_long = 1'b1;
      restart();
      grab(64);
      frame_chk("R1 R3 route", exp_frame(smp_l[s*20 +: 20], smp_r[s*20 +: 20], 1'b1, 1'b0));
    end
  endtask

  task automatic t_short();
    src_sel = 2'b01; fmt_long = 1'b0;
    restart();
    grab(64);
    frame_chk("R4 short msb first", exp_frame(smp_l[20 +: 20], smp_r[20 +: 20], 1'b0, 1'b0));
  endtask

  task automatic t_mute();
    src_sel = 2'b11; fmt_long = 1'b1;
    restart();
    grab(64);
    frame_chk("R2 mute", 64'h0);
  endtask

  task automatic t_conceal();
    logic [19:0] a, b;
    a = 20'h5A5A5; b = 20'h3C3C3;
    src_sel = 2'b10; fmt_long = 1'b1;
    smp_l[40 +: 20] = a; smp_r[40 +: 20] = b;
    restart();
    grab(64);
    frame_chk("R7 good frame", exp_frame(a, b, 1'b1, 1'b0));
    smp_l[40 +: 20] = 20'hC0FFE; smp_r[40 +: 20] = 20'h77777; err_l = 3'b100;
    gi = 0; grab(64);
    frame_chk("R7 left concealed", exp_frame(a, 20'h77777, 1'b1, 1'b0));
    smp_l[40 +: 20] = 20'h13579; smp_r[40 +: 20] = 20'h24680; err_l = 3'b000; err_r = 3'b100;
    gi = 0; grab(64);
    frame_chk("R7 right concealed", exp_frame(20'h13579, 20'h77777, 1'b1, 1'b0));
    err_r = '0;
  endtask

  task automatic t_midframe();
    smp_l[0 +: 20] = 20'h8421F; smp_r[0 +: 20] = 20'h0F0F1;
    smp_l[20 +: 20] = 20'hE7D3B; smp_r[20 +: 20] = 20'h6B2A9;
    src_sel = 2'b00; fmt_long = 1'b1;
    restart();
    grab(10);
    src_sel = 2'b01; fmt_long = 1'b0;
    grab(54);
    frame_chk("R11 no mid-frame change", exp_frame(20'h8421F, 20'h0F0F1, 1'b1, 1'b0));
    gi = 0; grab(64);
    frame_chk("R11 change at next frame", exp_frame(20'hE7D3B, 20'h6B2A9, 1'b0, 1'b0));
  endtask

  task automatic t_stop();
    int bad;
    smp_l[0 +: 20] = 20'h2468A; smp_r[0 +: 20] = 20'h9BDF1;
    src_sel = 2'b00; fmt_long = 1'b1;
    restart();
    grab(20);
    stop = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      if (bclk_o || wclk_o || sdata_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 outputs low in stop", 64'(bad), 64'h0);
    err_l = 3'b001; err_r = 3'b001;
    smp_l[0 +: 20] = 20'h11111; smp_r[0 +: 20] = 20'h22222;
    stop = 1'b0; gi = 0;
    grab(64);
    frame_chk("R10 R7 clean restart keeps store", exp_frame(20'h2468A, 20'h9BDF1, 1'b1, 1'b0));
    err_l = '0; err_r = '0;
  endtask

  task automatic t_lock();
    int bad;
    src_sel = 2'b00; fmt_long = 1'b1;
    restart();
    grab(5);
    lock = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (bclk_o || wclk_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 clocks parked while unlocked", 64'(bad), 64'h0);
    lock = 1'b1;
    restart();
    grab(64);
    frame_chk("R9 relock frame", exp_frame(smp_l[0 +: 20], smp_r[0 +: 20], 1'b1, 1'b0));
  endtask

  task automatic t_pace();
    int c0;
    pace = 3;
    src_sel = 2'b01; fmt_long = 1'b0;
    restart();
    grab(1);
    c0 = cyc;
    grab(1);
    chk((cyc - c0) == 6, "R12 R6 bit period follows enable", 64'(cyc - c0), 64'd6);
    grab(62);
    frame_chk("R12 slow enable frame", exp_frame(smp_l[20 +: 20], smp_r[20 +: 20], 1'b0, 1'b0));
    pace = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_route();
    t_short();
    t_mute();
    t_conceal();
    t_midframe();
    t_stop();
    t_lock();
    t_pace();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule